// File: doc/BRIEF.md
# UART Receive Status Tracker

This block sits between a UART receive deserialiser and the host register interface. Each character that the deserialiser finishes arrives as a one-cycle strobe, together with the byte and three error flags: parity, framing and break. The character is queued in a 64-entry receive FIFO. Its flags are stored in the same entry, so the error bits that the host sees always describe the character it is about to read.

The host sees two things. The first is the data at the head of the FIFO, which is popped by a data-register read strobe. The second is an 8-bit line status byte, whose sticky bits clear on a status-register read strobe. A character that completes while the FIFO is full is discarded and raises the overrun bit. A break event puts exactly one zero-valued character into the FIFO. A summary bit reports whether any queued entry carries an error.

Top module: `rx_status_tracker`

## Requirements
- R1: After reset the status byte is 0x00, the FIFO is empty and the read data is 0x00.
- R2: Status bit 0 (data ready) is 1 exactly when the FIFO holds at least one character.
- R3: A received-character strobe that is accepted while the FIFO is not full appends the byte and its flags to the tail. The read data output always shows the byte at the head, and shows 0x00 when the FIFO is empty.
- R4: A data read strobe removes the head entry when the FIFO is not empty. A data read strobe on an empty FIFO has no effect.
- R5: A character accepted while the FIFO holds 64 entries is dropped, the FIFO contents are left unchanged, and status bit 1 (overrun) is set. A read in the same cycle does not make room for that character.
- R6: Overrun clears on the clock edge that ends a status read cycle. If a new overrun occurs in that same cycle, the bit stays set.
- R7: Status bit 2 (parity error), bit 3 (framing error) and bit 4 (break) are the flags of the head entry, and are 0 when the FIFO is empty.
- R8: A break strobe is queued with data 0x00 and its break flag set. Further break strobes are ignored entirely, with no push and no overrun, until a strobe without the break flag arrives.
- R9: Status bit 7 is 1 while any queued entry has a parity, framing or break flag. A status read forces it to 0 for the next cycle, and it returns to 1 a cycle later if flagged entries remain.
- R10: Status bits 5 and 6 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | One-cycle strobe: a character has completed |
| rxData | input | 8 | Received byte |
| rxParityErr | input | 1 | Parity check failed for this character |
| rxFrameErr | input | 1 | Stop bit missing for this character |
| rxBreak | input | 1 | Line was held low for a whole frame |
| dataRd | input | 1 | Host read strobe of the data register (pops) |
| statusRd | input | 1 | Host read strobe of the status register |
| rdData | output | 8 | Byte at the head of the FIFO |
| statusByte | output | 8 | Line status: bit0 ready, bit1 overrun, bit2 parity, bit3 framing, bit4 break, bit7 FIFO error |

## Verification
Each fault in the queue becomes visible at the ports, and most become visible within a cycle.
- A pointer or count that drifts shows up as wrong head data, or as a wrong ready bit when the FIFO empties.
- Flags stored in the wrong entry show up in bits 2 to 4 at the first pop that reaches that entry.
- A miscounted error tally makes bit 7 disagree with the queued flags. This shows on the cycle after the last flagged entry leaves, or on the cycle after a status read.
- Wrong break or overrun state changes what is queued, so the difference shows when the FIFO is drained.

The bench keeps its own queue model and compares every port on every cycle, so the first wrong cycle is reported directly.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;

  // Per-character error flags stored alongside each byte.
  typedef struct packed {
    logic brk;
    logic frame;
    logic parity;
  } rxFlags_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic push;
    logic pop;
    logic zeroData;
  } dpStrobe_t;

  localparam int FLAG_W = $bits(rxFlags_t);

endpackage

// File: rtl/rx_status_dp.sv
module rx_status_dp
  import rx_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] inData,
  input  rxFlags_t          inFlags,
  output logic [DATA_W-1:0] headData,
  output rxFlags_t          headFlags,
  output logic              full,
  output logic              empty,
  output logic              errRemainNext
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] DEPTH_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] dataMem [DEPTH];
  rxFlags_t          flagMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count, countNxt;
  logic [CNT_W-1:0]  errCnt, errCntNxt;
  logic              errIn, errOut;
  logic [DATA_W-1:0] storeData;

  assign full  = (count == DEPTH_CNT);
  assign empty = (count == '0);

  assign storeData = strb.zeroData ? '0 : inData;
  assign errIn  = strb.push & (|inFlags);
  assign errOut = strb.pop  & (|flagMem[rdPtr]);

  always_comb begin
    countNxt  = count + CNT_W'(strb.push) - CNT_W'(strb.pop);
    errCntNxt = errCnt + CNT_W'(errIn) - CNT_W'(errOut);
  end

  assign errRemainNext = (errCntNxt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      errCnt <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count  <= countNxt;
      errCnt <= errCntNxt;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      dataMem[wrPtr] <= storeData;
      flagMem[wrPtr] <= inFlags;
    end
  end

  assign headData  = empty ? '0 : dataMem[rdPtr];
  assign headFlags = empty ? '0 : flagMem[rdPtr];

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full);

  // R4
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= DEPTH_CNT);

  // R9
  err_tally_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCnt <= count);

endmodule

// File: rtl/rx_status_ctrl.sv
module rx_status_ctrl
  import rx_status_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxValid,
  input  logic      rxBreak,
  input  logic      dataRd,
  input  logic      statusRd,
  input  logic      full,
  input  logic      empty,
  input  logic      errRemainNext,
  output dpStrobe_t strb,
  output logic      overrun,
  output logic      errFlag
);

  logic inBreak;
  logic dupBreak;
  logic accept;
  logic setOvr;

  assign dupBreak = rxValid & rxBreak & inBreak;
  assign accept   = rxValid & ~dupBreak;
  assign setOvr   = accept & full;

  always_comb begin
    strb          = '0;
    strb.push     = accept & ~full;
    strb.pop      = dataRd & ~empty;
    strb.zeroData = rxBreak;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBreak <= 1'b0;
      overrun <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      if (rxValid) inBreak <= rxBreak;
      if (setOvr)        overrun <= 1'b1;
      else if (statusRd) overrun <= 1'b0;
      errFlag <= statusRd ? 1'b0 : errRemainNext;
    end
  end

  // R6
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRd && !(rxValid && full)) |=> !overrun);

  // R8
  break_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak && inBreak) |-> !strb.push);

  // R9
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |=> !errFlag);

  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxBreak && full) |=> overrun);

endmodule

// File: rtl/rx_status_tracker.sv
module rx_status_tracker
  import rx_status_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  input  logic              rxBreak,
  input  logic              dataRd,
  input  logic              statusRd,
  output logic [DATA_W-1:0] rdData,
  output logic [7:0]        statusByte
);

  dpStrobe_t strb;
  rxFlags_t  inFlags, headFlags;
  logic      full, empty, errRemainNext;
  logic      overrun, errFlag;

  always_comb begin
    inFlags        = '0;
    inFlags.parity = rxParityErr;
    inFlags.frame  = rxFrameErr;
    inFlags.brk    = rxBreak;
  end

  rx_status_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .rxValid       (rxValid),
    .rxBreak       (rxBreak),
    .dataRd        (dataRd),
    .statusRd      (statusRd),
    .full          (full),
    .empty         (empty),
    .errRemainNext (errRemainNext),
    .strb          (strb),
    .overrun       (overrun),
    .errFlag       (errFlag)
  );

  rx_status_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .inData        (rxData),
    .inFlags       (inFlags),
    .headData      (rdData),
    .headFlags     (headFlags),
    .full          (full),
    .empty         (empty),
    .errRemainNext (errRemainNext)
  );

  assign statusByte = {errFlag, 2'b00, headFlags.brk, headFlags.frame,
                       headFlags.parity, overrun, ~empty};

  // R7
  head_flags_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (statusByte[4:2] == 3'b000));

  // R10
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:5] == 2'b00);

endmodule

// File: tb/rx_status_tracker_bench.sv
module rx_status_tracker_bench;

  localparam int DEPTH = 64;
  localparam int MAX_CYCLES = 100000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rxParityErr = 1'b0, rxFrameErr = 1'b0, rxBreak = 1'b0;
  logic       dataRd = 1'b0, statusRd = 1'b0;
  logic [7:0] rdData, statusByte;

  int errs = 0;
  int checks = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  rx_status_tracker u_rx_status_tracker (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak),
    .dataRd(dataRd), .statusRd(statusRd), .rdData(rdData), .statusByte(statusByte)
  );

  // Behavioural reference model; flags packed as {brk, frame, parity}.
  logic [7:0] qData[$];
  logic [2:0] qFlag[$];
  bit mOvr, mInBreak, mErrFlag;

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      qData.delete(); qFlag.delete();
      mOvr = 0; mInBreak = 0; mErrFlag = 0;
    end else begin
      bit wasFull, dup, acc;
      int nErr;
      wasFull = (qData.size() == DEPTH);
      dup = rxValid && rxBreak && mInBreak;
      acc = rxValid && !dup;
      if (dataRd && qData.size() != 0) begin
        void'(qData.pop_front()); void'(qFlag.pop_front());
      end
      if (acc && !wasFull) begin
        qData.push_back(rxBreak ? 8'h00 : rxData);
        qFlag.push_back({rxBreak, rxFrameErr, rxParityErr});
      end
      if (rxValid) mInBreak = rxBreak;
      if (acc && wasFull) mOvr = 1;
      else if (statusRd) mOvr = 0;
      nErr = 0;
      foreach (qFlag[i]) if (qFlag[i] != 3'b000) nErr++;
      mErrFlag = statusRd ? 0 : (nErr != 0);
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    bit ne;
    ne = (qData.size() != 0);
    check("R2 ready", statusByte[0], ne);
    check("R5 R6 overrun", statusByte[1], mOvr);
    check("R7 head flags", statusByte[4:2], ne ? qFlag[0] : 3'b000);
    check("R10 reserved", statusByte[6:5], 0);
    check("R9 fifo error", statusByte[7], mErrFlag);
    check("R3 head data", rdData, ne ? qData[0] : 8'h00);
  endtask

  // One cycle: compare outputs at the falling edge, then drive the next inputs.
  task automatic step(input bit v, input logic [7:0] d, input bit pe, input bit fe,
                      input bit br, input bit drd, input bit srd);
    @(negedge clk);
    if (rstN) compareAll();
    rxValid = v; rxData = d; rxParityErr = pe; rxFrameErr = fe; rxBreak = br;
    dataRd = drd; statusRd = srd;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", statusByte, 8'h00);
    check("R1 data", rdData, 8'h00);

    // R3 R7 mixed flags, then pops
    step(1, 8'h11, 0, 0, 0, 0, 0);
    step(1, 8'h22, 1, 0, 0, 0, 0);
    step(1, 8'h33, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);

    // R4 read on empty FIFO
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R4 empty read", statusByte[0], 0);
    check("R4 empty data", rdData, 8'h00);

    // R8 break event: three break strobes then a normal character
    step(1, 8'hA5, 0, 1, 1, 0, 0);
    step(1, 8'hA5, 0, 1, 1, 0, 0);
    step(1, 8'h5A, 0, 0, 1, 0, 0);
    step(1, 8'h77, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R8 break data", rdData, 8'h00);
    check("R8 break flag", statusByte[4], 1);
    step(0, 0, 0, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R8 single break", rdData, 8'h77);
    check("R8 next flags", statusByte[4:2], 3'b000);
    step(0, 0, 0, 0, 0, 1, 0);

    // R5 fill to the limit, then overrun, including a simultaneous read
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i + 8'h40), 0, 0, 0, 0, 0);
    step(1, 8'hEE, 0, 0, 0, 0, 0);
    step(1, 8'hEF, 1, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R5 overrun set", statusByte[1], 1);
    step(0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    check("R6 overrun clear", statusByte[1], 0);
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 0, 0, 1, 0);

    // Random traffic
    for (int i = 0; i < 6000; i++) begin
      int r;
      bit v, br;
      r = $urandom_range(0, 99);
      v = ($urandom_range(0, 99) < 55);
      br = ($urandom_range(0, 99) < 10);
      step(v, 8'($urandom), ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
           br, (r < 45), ($urandom_range(0, 99) < 15));
    end
    step(0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    wait (cycles >= MAX_CYCLES);
    errs++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, MAX_CYCLES);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule